// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Enforcer

This block sits between a memory scheduler and the command pins of a DDR SDRAM. The scheduler offers one command at a time with a bank, an address word and a burst-length code. The block holds that request until every inter-command delay that applies to it has passed, then issues it. It tracks which of the banks hold an open row, and it keeps per-bank countdowns for row-to-column delay, minimum row-open time, row cycle, precharge recovery and write recovery. It also keeps shared countdowns for activate spacing, data-bus occupancy, write-to-read turnaround and the mode-register settle time.

Every delay is a parameter counted in clocks. The scheduler raises `req_valid` and keeps the request steady. The request is taken on the first rising edge at which `req_ready` is high, and the command appears on the output one clock later. In every other cycle the output carries NOP.

Top module: `ddr_bank_timer`

## Requirements
- R1: A READ or WRITE to a bank is issued no earlier than T_RCD clocks after that bank's ACTIVATE was issued.
- R2: A READ or WRITE is accepted only for a bank with an open row, and an ACTIVATE only for an idle bank. Otherwise `req_ready` stays low. Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, MODE-SET=5, REFRESH=6. Codes 0 and 7 are never accepted.
- R3: A PRECHARGE of an open bank waits T_RAS clocks after its ACTIVATE and T_WR clocks after its last write data. When `req_addr[10]` is 1, the PRECHARGE closes all banks and waits until every open bank meets both limits. A PRECHARGE of an idle bank is accepted at once.
- R4: An ACTIVATE to a bank waits T_RC clocks after the previous ACTIVATE of that bank and T_RP clocks after its PRECHARGE. Two ACTIVATEs to any banks are at least T_RRD clocks apart.
- R5: `req_bl` codes the burst as 0=2 beats, 1=4 beats, and 2 or 3=8 beats. A burst holds the data bus for half its beats in clocks. The next READ or WRITE waits the larger of that and T_CCD.
- R6: The last write data lands 1 + BL/2 clocks after a WRITE is issued. A READ to any bank waits T_CDLR clocks after that point, so a write burst is never cut by a read.
- R7: A WRITE with `req_addr[10]` = 1 closes its bank by itself, and the next ACTIVATE of that bank waits T_DAL clocks after the last write data. A READ ignores `req_addr[10]` and leaves the row open.
- R8: A MODE-SET is accepted only when every bank is idle and free to activate. No command of any kind is issued in the T_MRD-1 clocks that follow it.
- R9: A REFRESH is accepted under the same idle condition as a MODE-SET. It holds every ACTIVATE off for T_RFC clocks.
- R10: `cmd_out`, `cmd_bank` and `cmd_addr` are registered. They show an accepted request one clock after acceptance and NOP otherwise. Reset closes every bank, clears every timer and drives NOP.
- R11: `req_ready` is high only while `req_valid` is high and the request is legal now. An unconstrained request is taken at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler offers a command |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BW | Target bank |
| req_addr | input | AW | Row for ACTIVATE, column for READ/WRITE, key for MODE-SET; bit 10 selects all-bank or auto-close |
| req_bl | input | 2 | Burst-length code |
| req_ready | output | 1 | Request is taken at this edge |
| cmd_out | output | 3 | Issued command code, NOP when idle |
| cmd_bank | output | BW | Bank of the issued command |
| cmd_addr | output | AW | Address of the issued command |

## Verification
The hardest state to reach is one where several limits overlap on the same request. Examples are a PRECHARGE-all held by the newest ACTIVATE while an older bank is already clear, or a READ held by write turnaround after bus occupancy has expired. Reaching these takes a long chain of dependent commands. The stimulus is therefore one ordered sequence in which each request is presented as soon as the previous one was issued. The expected stall of each request is worked out by hand from the limits in force at that moment. The refusal cases come after the sequence, with a bank left open: MODE-SET with an open bank, a column command to an idle bank, and ACTIVATE to an open bank. Each is held for many cycles to show that it is never taken.

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
  parameter int NBANK  = 4,
  parameter int AW     = 12,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 5,
  parameter int T_RAS  = 10,
  parameter int T_RC   = 15,
  parameter int T_RP   = 5,
  parameter int T_RRD  = 2,
  parameter int T_WR   = 3,
  parameter int T_CDLR = 2,
  parameter int T_CCD  = 1,
  parameter int T_DAL  = 8,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 17,
  localparam int BW    = $clog2(NBANK),
  localparam int CW    = $clog2(T_RFC + T_RC + T_DAL + T_WR + T_CDLR + T_RAS + 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_bl,
  output logic          req_ready,
  output logic [2:0]    cmd_out,
  output logic [BW-1:0] cmd_bank,
  output logic [AW-1:0] cmd_addr
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_MRS = 3'd5, C_REF = 3'd6;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [NBANK-1:0] open_q, bank_rest, bank_pre_ok;
  logic [CW-1:0]    rcd_q [NBANK];
  logic [CW-1:0]    ras_q [NBANK];
  logic [CW-1:0]    act_q [NBANK];
  logic [CW-1:0]    wr_q  [NBANK];
  logic [CW-1:0]    rrd_q, col_q, wtr_q, mrd_q;
  logic [CW-1:0]    half, col_gap;
  logic             legal, acc, ap;

  assign half    = (req_bl == 2'd0) ? CW'(1) : (req_bl == 2'd1) ? CW'(2) : CW'(4);
  assign col_gap = (half > CW'(T_CCD)) ? half - 1'b1 : CW'(T_CCD - 1);
  assign ap      = req_addr[AP_BIT];

  always_comb begin
    case (req_cmd)
      C_ACT:        legal = !open_q[req_bank] && act_q[req_bank] == '0 && rrd_q == '0;
      C_RD:         legal = open_q[req_bank] && rcd_q[req_bank] == '0 && col_q == '0 && wtr_q == '0;
      C_WR:         legal = open_q[req_bank] && rcd_q[req_bank] == '0 && col_q == '0;
      C_PRE:        legal = ap ? &bank_pre_ok : bank_pre_ok[req_bank];
      C_MRS, C_REF: legal = &bank_rest;
      default:      legal = 1'b0;
    endcase
  end

  assign req_ready = req_valid && legal && mrd_q == '0;
  assign acc       = req_ready;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          hit, pre_hit;
    logic [CW-1:0] act_load;

    assign hit            = acc && req_bank == BW'(b);
    assign pre_hit        = acc && req_cmd == C_PRE && (ap || req_bank == BW'(b));
    assign bank_rest[b]   = !open_q[b] && act_q[b] == '0;
    assign bank_pre_ok[b] = !open_q[b] || (ras_q[b] == '0 && wr_q[b] == '0);

    always_comb begin
      act_load = '0;
      if (hit && req_cmd == C_ACT)            act_load = CW'(T_RC - 1);
      if (pre_hit)                            act_load = CW'(T_RP - 1);
      if (hit && req_cmd == C_WR && ap)       act_load = half + CW'(T_DAL);
      if (acc && req_cmd == C_REF)            act_load = CW'(T_RFC - 1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        rcd_q[b]  <= '0;
        ras_q[b]  <= '0;
        act_q[b]  <= '0;
        wr_q[b]   <= '0;
      end else begin
        rcd_q[b] <= (hit && req_cmd == C_ACT) ? CW'(T_RCD - 1) : dec(rcd_q[b]);
        ras_q[b] <= (hit && req_cmd == C_ACT) ? CW'(T_RAS - 1) : dec(ras_q[b]);
        wr_q[b]  <= (hit && req_cmd == C_WR) ? mx(dec(wr_q[b]), half + CW'(T_WR))
                                             : dec(wr_q[b]);
        act_q[b] <= mx(dec(act_q[b]), act_load);
        if (hit && req_cmd == C_ACT)            open_q[b] <= 1'b1;
        else if (pre_hit)                       open_q[b] <= 1'b0;
        else if (hit && req_cmd == C_WR && ap)  open_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q    <= '0;
      col_q    <= '0;
      wtr_q    <= '0;
      mrd_q    <= '0;
      cmd_out  <= C_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else begin
      rrd_q <= (acc && req_cmd == C_ACT) ? CW'(T_RRD - 1) : dec(rrd_q);
      col_q <= (acc && (req_cmd == C_RD || req_cmd == C_WR)) ? col_gap : dec(col_q);
      wtr_q <= (acc && req_cmd == C_WR) ? mx(dec(wtr_q), half + CW'(T_CDLR)) : dec(wtr_q);
      mrd_q <= (acc && req_cmd == C_MRS) ? CW'(T_MRD - 1) : dec(mrd_q);
      cmd_out  <= acc ? req_cmd  : C_NOP;
      cmd_bank <= acc ? req_bank : '0;
      cmd_addr <= acc ? req_addr : '0;
    end
  end

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> cmd_out == C_NOP); // R10

  if (T_RCD >= 2) begin : g_a_rcd
    AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out == C_ACT |=> !((cmd_out == C_RD || cmd_out == C_WR) && cmd_bank == $past(cmd_bank))); // R1
  end
  if (T_RAS >= 2) begin : g_a_ras
    AST_ACT_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out == C_ACT |=> !(cmd_out == C_PRE && cmd_bank == $past(cmd_bank))); // R3
  end
  if (T_RRD >= 2) begin : g_a_rrd
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out == C_ACT |=> cmd_out != C_ACT); // R4
  end
  if (T_MRD >= 2) begin : g_a_mrd
    AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out == C_MRS |=> cmd_out == C_NOP); // R8
  end
  if (T_RFC >= 2) begin : g_a_rfc
    AST_REF_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out == C_REF |=> cmd_out != C_ACT); // R9
  end
endmodule

// File: tb/ddr_bank_timer_tb.sv
module ddr_bank_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = '0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_bl = '0;
  logic        req_ready;
  logic [2:0]  cmd_out;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ddr_bank_timer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_addr(req_addr), .req_bl(req_bl), .req_ready(req_ready),
    .cmd_out(cmd_out), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  // {cmd, bank, addr, bl, expected stall in clocks}
  localparam logic [26:0] VEC [16] = '{
    {3'd1, 2'd0, 12'h123, 2'd0, 8'd0},
    {3'd1, 2'd1, 12'h045, 2'd0, 8'd1},
    {3'd2, 2'd0, 12'h010, 2'd1, 8'd2},
    {3'd3, 2'd1, 12'h020, 2'd1, 8'd1},
    {3'd2, 2'd0, 12'h408, 2'd0, 8'd4},
    {3'd2, 2'd0, 12'h00c, 2'd0, 8'd0},
    {3'd4, 2'd1, 12'h000, 2'd0, 8'd0},
    {3'd1, 2'd1, 12'h046, 2'd0, 8'd4},
    {3'd4, 2'd0, 12'h000, 2'd0, 8'd0},
    {3'd1, 2'd0, 12'h124, 2'd0, 8'd4},
    {3'd3, 2'd0, 12'h430, 2'd2, 8'd4},
    {3'd1, 2'd0, 12'h125, 2'd0, 8'd12},
    {3'd4, 2'd0, 12'h400, 2'd0, 8'd9},
    {3'd5, 2'd0, 12'h032, 2'd0, 8'd4},
    {3'd6, 2'd0, 12'h000, 2'd0, 8'd1},
    {3'd1, 2'd2, 12'h200, 2'd0, 8'd16}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R11";  1: return "R4";  2: return "R1";  3: return "R5";
      4: return "R6";   5: return "R7";  6: return "R3";  7: return "R4";
      8: return "R3";   9: return "R4"; 10: return "R1"; 11: return "R7";
      12: return "R3"; 13: return "R8"; 14: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [11:0] a,
                       input logic [1:0] bl, input int exp_wait, input string tag);
    int n = 0;
    req_cmd = c; req_bank = b; req_addr = a; req_bl = bl; req_valid = 1'b1;
    #1;
    while (!req_ready && n < 300) begin
      @(negedge clk); #1;
      n++;
    end
    check({tag, " stall"}, n, exp_wait);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " issued cmd/bank"}, {cmd_out, cmd_bank}, {c, b});
  endtask

  task automatic refuse(input logic [2:0] c, input logic [1:0] b, input string tag);
    int seen = 0;
    req_cmd = c; req_bank = b; req_addr = 12'h000; req_bl = 2'd0; req_valid = 1'b1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk); #1;
      if (req_ready || cmd_out != 3'd0) seen++;
    end
    check({tag, " refused request"}, seen, 0);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset cmd_out", cmd_out, 0);
    check("R11 ready without valid", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", cmd_out, 0);

    for (int i = 0; i < 16; i++)
      issue(VEC[i][26:24], VEC[i][23:22], VEC[i][21:10], VEC[i][9:8], int'(VEC[i][7:0]), tag_of(i));

    repeat (20) @(negedge clk);
    refuse(3'd5, 2'd0, "R8 mode-set with bank 2 open");
    refuse(3'd6, 2'd0, "R9 refresh with bank 2 open");
    refuse(3'd2, 2'd3, "R2 read to idle bank");
    refuse(3'd1, 2'd2, "R2 activate to open bank");
    refuse(3'd7, 2'd0, "R2 reserved code");

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset mid-run", cmd_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd1, 2'd2, 12'h201, 2'd0, 0, "R10 bank cleared by reset");
    issue(3'd2, 2'd2, 12'h001, 2'd2, 4, "R1 read after fresh activate");
    finish_run();
  end
endmodule